// File: doc/BRIEF.md
# Transmit Frame Loader

This block sits between a host write port and a transmit engine. The host pushes 16-bit words into a 6 KB transmit buffer while a DMA-access gate is held open. Each frame is written as a control word carrying a frame ID, then a byte-count word, then the frame data, padded by the host to a 4-byte boundary.

A write pointer selects the buffer word that each write goes to. The pointer can be loaded directly. It advances after each stored word when auto-increment is on.

The block parses the header of each frame and checks the frame against the free-space figure it maintains. It reserves space for frames that fit and rejects frames that do not. Complete frames are held back until the host issues an enqueue command. The transmit engine reads the buffer through a read port. It returns a frame's space by pulsing a done signal together with that frame's byte count.

Top module: `tx_frame_loader`

## Requirements
- R1: After reset, `free_bytes` is 6144, `overflow` is 0 and `pending` is 0.
- R2: A write presented while `dma_en` is 0 is ignored. It stores nothing, leaves the pointer where it was and does not advance header parsing.
- R3: An accepted write stores `wr_data` at the word address held in the pointer. When `auto_inc` is 1, the pointer then advances by one and wraps from 3071 to 0. When `auto_inc` is 0, the pointer stays where it is.
- R4: `ptr_load` sets the pointer to `ptr_value` on the next edge. A write presented in the same cycle is ignored.
- R5: Accepted words are parsed per frame in a fixed order. Word 0 is the control word. Word 1 is the byte count, taken from bits [11:0]. Then come round4(count)/2 data words, where round4 rounds up to a multiple of 4. A count of 0 completes the frame at its second word.
- R6: When a byte-count word is accepted and 4 + round4(count) is no greater than `free_bytes`, `free_bytes` drops by that amount on the next cycle. A frame that exactly fills the space is accepted.
- R7: When 4 + round4(count) exceeds `free_bytes`, the frame is rejected. `overflow` becomes 1, `free_bytes` is unchanged, and the pointer returns to the address of that frame's control word. The frame's data words are discarded without being stored and without moving the pointer.
- R8: `overflow` stays at 1 until an `ovf_clr` pulse clears it. A rejection in the same cycle as `ovf_clr` takes priority.
- R9: Completed frames are not counted in `pending` until an `enqueue` pulse. The pulse adds every frame completed since the previous pulse, including a frame that completes in the same cycle.
- R10: A `frame_done` pulse with `done_len` adds 4 + round4(`done_len`) to `free_bytes` and lowers `pending` by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en | input | 1 | DMA-access gate; writes count only while this is 1 |
| auto_inc | input | 1 | Advance the pointer after each stored word |
| ptr_load | input | 1 | Load the pointer from `ptr_value` |
| ptr_value | input | 12 | New pointer value (word address) |
| wr_valid | input | 1 | Write strobe |
| wr_data | input | 16 | Write word |
| enqueue | input | 1 | Release the frames loaded so far |
| ovf_clr | input | 1 | Clear the overflow flag |
| frame_done | input | 1 | Transmit engine has finished one frame |
| done_len | input | 12 | Byte count of the finished frame |
| rd_addr | input | 12 | Transmit engine read address (word) |
| rd_data | output | 16 | Buffer word at `rd_addr`, one cycle later |
| free_bytes | output | 13 | Free space in bytes |
| overflow | output | 1 | Sticky frame-rejected flag |
| pending | output | 8 | Frames enqueued but not yet finished |

## Verification
The assertions assume that the transmit engine pulses `frame_done` only while `pending` is non-zero. They also assume that `done_len` matches the byte count of a frame that was actually enqueued, so the free space never grows past 6144. The stimulus keeps to this by returning only frames it has already enqueued, each with the length it wrote. It never loads the pointer in the middle of a header, so the rollback address is always the control word of the current frame.

// File: rtl/tx_frame_loader.sv
module tx_frame_loader #(
  parameter int DEPTH_BYTES = 6144,
  parameter int LEN_W = 12,
  parameter int CNT_W = 8,
  localparam int WORDS = DEPTH_BYTES / 2,
  localparam int AW = $clog2(WORDS),
  localparam int FW = $clog2(DEPTH_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_en,
  input  logic             auto_inc,
  input  logic             ptr_load,
  input  logic [AW-1:0]    ptr_value,
  input  logic             wr_valid,
  input  logic [15:0]      wr_data,
  input  logic             enqueue,
  input  logic             ovf_clr,
  input  logic             frame_done,
  input  logic [LEN_W-1:0] done_len,
  input  logic [AW-1:0]    rd_addr,
  output logic [15:0]      rd_data,
  output logic [FW-1:0]    free_bytes,
  output logic             overflow,
  output logic [CNT_W-1:0] pending
);

  typedef enum logic [1:0] {S_CTRL, S_LEN, S_DATA, S_SKIP} st_t;

  st_t              st;
  logic [AW-1:0]    wptr, fstart;
  logic [LEN_W-1:0] rem;
  logic [CNT_W-1:0] loaded;
  logic [15:0]      mem [WORDS];

  wire acc = wr_valid && dma_en && !ptr_load;

  wire [LEN_W:0] len_r4  = ({1'b0, wr_data[LEN_W-1:0]} + (LEN_W+1)'(3)) & ~(LEN_W+1)'(3);
  wire [LEN_W:0] done_r4 = ({1'b0, done_len} + (LEN_W+1)'(3)) & ~(LEN_W+1)'(3);
  wire [FW-1:0]  need    = FW'(len_r4) + FW'(4);
  wire [FW-1:0]  rel     = FW'(done_r4) + FW'(4);
  wire [LEN_W-1:0] nwords = LEN_W'(len_r4 >> 1);

  wire hdr_len = acc && (st == S_LEN);
  wire reject  = hdr_len && (need > free_bytes);
  wire take    = hdr_len && !reject;
  wire store   = acc && (st != S_SKIP);
  wire fin     = (take && nwords == '0) || (acc && st == S_DATA && rem == LEN_W'(1));

  wire [AW-1:0]    ptr_inc  = (wptr == AW'(WORDS - 1)) ? '0 : wptr + 1'b1;
  wire [CNT_W-1:0] loaded_n = loaded + CNT_W'(fin);

  always_ff @(posedge clk) begin
    if (store) mem[wptr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_CTRL;
      wptr       <= '0;
      fstart     <= '0;
      rem        <= '0;
      loaded     <= '0;
      pending    <= '0;
      overflow   <= 1'b0;
      free_bytes <= FW'(DEPTH_BYTES);
    end else begin
      if (ptr_load)               wptr <= ptr_value;
      else if (reject)            wptr <= fstart;
      else if (store && auto_inc) wptr <= ptr_inc;

      if (acc && st == S_CTRL) fstart <= wptr;

      if (acc) begin
        case (st)
          S_CTRL: st <= S_LEN;
          S_LEN: begin
            rem <= nwords;
            if (nwords == '0) st <= S_CTRL;
            else              st <= reject ? S_SKIP : S_DATA;
          end
          default: begin
            rem <= rem - 1'b1;
            if (rem == LEN_W'(1)) st <= S_CTRL;
          end
        endcase
      end

      free_bytes <= free_bytes - (take ? need : '0) + (frame_done ? rel : '0);

      if (reject)       overflow <= 1'b1;
      else if (ovf_clr) overflow <= 1'b0;

      if (enqueue) begin
        pending <= pending + loaded_n - CNT_W'(frame_done);
        loaded  <= '0;
      end else begin
        pending <= pending - CNT_W'(frame_done);
        loaded  <= loaded_n;
      end
    end
  end

  a_r6_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
    free_bytes <= FW'(DEPTH_BYTES));
  a_r2_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && !ptr_load) |=> $stable(wptr));
  a_r4_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> (wptr == $past(ptr_value)));
  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> overflow);
  a_r7_free_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && !frame_done) |=> $stable(free_bytes));
  a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !reject) |=> !overflow);
  a_r10_done_pending: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (pending != '0));

endmodule

// File: tb/tx_frame_loader_test.sv
module tx_frame_loader_test;
  localparam int WORDS = 3072;

  logic clk = 0, rst_n = 0;
  logic dma_en = 0, auto_inc = 0, ptr_load = 0, wr_valid = 0;
  logic enqueue = 0, ovf_clr = 0, frame_done = 0;
  logic [11:0] ptr_value = 0, done_len = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic [12:0] free_bytes;
  logic overflow;
  logic [7:0] pending;

  tx_frame_loader uut (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .auto_inc(auto_inc),
    .ptr_load(ptr_load), .ptr_value(ptr_value), .wr_valid(wr_valid),
    .wr_data(wr_data), .enqueue(enqueue), .ovf_clr(ovf_clr),
    .frame_done(frame_done), .done_len(done_len), .rd_addr(rd_addr),
    .rd_data(rd_data), .free_bytes(free_bytes), .overflow(overflow),
    .pending(pending)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  int m_ptr, m_fstart, m_state, m_rem, m_loaded, m_pend, m_free, m_ovf;
  int m_mem [WORDS];
  bit m_val [WORDS];
  int m_rd;
  bit m_rdv;

  function automatic int r4(input int n);
    return (n + 3) / 4 * 4;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ptr = 0; m_fstart = 0; m_state = 0; m_rem = 0;
      m_loaded = 0; m_pend = 0; m_free = 6144; m_ovf = 0; m_rdv = 0;
    end else begin
      bit acc, rej, tk, fin;
      int len, nd, nxt_ptr;
      m_rd = m_mem[rd_addr]; m_rdv = m_val[rd_addr];
      acc = wr_valid && dma_en && !ptr_load;
      len = int'(wr_data[11:0]); nd = 4 + r4(len);
      rej = 0; tk = 0; fin = 0; nxt_ptr = m_ptr;
      if (acc) begin
        if (m_state != 3) begin
          m_mem[m_ptr] = int'(wr_data); m_val[m_ptr] = 1;
          if (auto_inc) nxt_ptr = (m_ptr + 1) % WORDS;
        end
        case (m_state)
          0: begin m_fstart = m_ptr; m_state = 1; end
          1: begin
            rej = nd > m_free; tk = !rej;
            m_rem = r4(len) / 2;
            if (m_rem == 0) begin m_state = 0; fin = tk; end
            else m_state = rej ? 3 : 2;
            if (rej) nxt_ptr = m_fstart;
          end
          default: begin
            m_rem--;
            if (m_rem == 0) begin fin = (m_state == 2); m_state = 0; end
          end
        endcase
      end
      if (ptr_load) nxt_ptr = int'(ptr_value);
      m_ptr = nxt_ptr;
      if (tk) m_free -= nd;
      if (frame_done) begin m_free += 4 + r4(int'(done_len)); m_pend--; end
      if (rej) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
      if (fin) m_loaded++;
      if (enqueue) begin m_pend += m_loaded; m_loaded = 0; end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && cyc > 1) begin
    chk("R6 free_bytes per-cycle", int'(free_bytes), m_free);
    chk("R7 overflow per-cycle", int'(overflow), m_ovf);
    chk("R9 pending per-cycle", int'(pending), m_pend);
    if (m_rdv) chk("R3 rd_data per-cycle", int'(rd_data), m_rd);
  end

  always @(posedge clk) if (cyc > 150000) begin
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic wr(input int w);
    wr_valid = 1; wr_data = 16'(w);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic frame(input int ctrl, input int len, input int seed);
    wr(ctrl); wr(len);
    for (int i = 0; i < r4(len) / 2; i++) wr((seed + i * 7) & 16'hFFFF);
  endtask

  task automatic pulse_enq();
    enqueue = 1; @(negedge clk); enqueue = 0; @(negedge clk);
  endtask

  task automatic load(input int a);
    ptr_load = 1; ptr_value = 12'(a); @(negedge clk); ptr_load = 0;
  endtask

  task automatic peek(input int a, output int v);
    rd_addr = 12'(a); @(negedge clk); @(negedge clk); v = int'(rd_data);
  endtask

  initial begin
    int v, p;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset free", int'(free_bytes), 6144);
    chk("R1 reset overflow", int'(overflow), 0);
    chk("R1 reset pending", int'(pending), 0);

    wr(16'hDEAD); wr(16'hBEEF);
    @(negedge clk);
    chk("R2 gated writes leave free", int'(free_bytes), 6144);

    dma_en = 1; auto_inc = 1;
    frame(16'h0011, 10, 100);
    @(negedge clk);
    chk("R6 free after 10-byte frame", int'(free_bytes), 6128);
    peek(0, v); chk("R2 R5 ctrl word at 0", v, 16'h0011);
    peek(1, v); chk("R5 length word at 1", v, 10);
    peek(2, v); chk("R3 first data at 2", v, 100);
    chk("R9 pending before enqueue", int'(pending), 0);
    pulse_enq();
    chk("R9 pending after enqueue", int'(pending), 1);

    frame(16'h0022, 0, 0);
    @(negedge clk);
    chk("R5 zero-length frame free", int'(free_bytes), 6124);

    auto_inc = 0; load(100);
    frame(16'h0033, 1, 500);
    peek(100, v); chk("R3 no-increment keeps last word", v, 507);
    auto_inc = 1;

    load(WORDS - 2);
    frame(16'h0044, 2, 900);
    peek(0, v); chk("R3 R4 pointer wraps to 0", v, 900);
    chk("R9 completed frames wait", int'(pending), 1);

    ptr_load = 1; ptr_value = 12'd300; wr(16'h7777); ptr_load = 0;
    wr(16'h0055); wr(8); wr(1); wr(2); wr(3); wr(4);
    peek(300, v); chk("R4 load wins over write", v, 16'h0055);

    frame(16'h0100, 2000, 1);
    frame(16'h0101, 2000, 2);
    frame(16'h0102, 2000, 3);
    @(negedge clk);
    chk("R6 free after big frames", int'(free_bytes), 84);

    p = m_ptr;
    frame(16'h0200, 200, 4);
    @(negedge clk);
    chk("R7 overflow set", int'(overflow), 1);
    chk("R7 free unchanged", int'(free_bytes), 84);
    frame(16'h0066, 80, 5);
    @(negedge clk);
    chk("R6 exact fit accepted", int'(free_bytes), 0);
    peek(p, v); chk("R7 pointer rolled back", v, 16'h0066);
    chk("R8 overflow held", int'(overflow), 1);
    ovf_clr = 1; @(negedge clk); ovf_clr = 0; @(negedge clk);
    chk("R8 overflow cleared", int'(overflow), 0);

    pulse_enq();
    chk("R9 pending after second enqueue", int'(pending), 9);
    frame_done = 1; done_len = 12'd10; @(negedge clk); frame_done = 0;
    @(negedge clk);
    chk("R10 free returned", int'(free_bytes), 16);
    chk("R10 pending lowered", int'(pending), 8);

    wr(16'h0077); wr(4);
    enqueue = 1; wr(5); wr(6); enqueue = 0;
    @(negedge clk);
    chk("R9 same-cycle completion enqueued", int'(pending), 9);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule